// File: doc/BRIEF.md
# I2C Register Slave

This block is a slave on a two-wire I2C bus, placed in front of a small bank of byte-wide registers. It samples SCL and SDA through two-flop synchronizers into a fast system clock. It finds START and STOP conditions and SCL edges in that clock domain. SDA is driven only as an open-drain pull-low enable, `sda_oe`.

A write transaction carries the 7-bit device address with R/W low, then a pointer byte, then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. A read transaction, usually entered through a repeated START after the pointer byte, returns bytes from the pointer onward, most significant bit first. It continues for as long as the master acknowledges. After a STOP, a wrong address or a master not-acknowledge, the block ignores SCL until the next START. An undervoltage input returns every register to its default value. The default of register i is 0x50 + 0x11·i, taken modulo 256.

The controller has seven states. IDLE ignores SCL. ADDR shifts in the address byte. ADDR_ACK drives the address acknowledge. WR_BYTE shifts in a pointer or data byte. WR_ACK drives the acknowledge for a write byte. RD_BYTE shifts out a data byte. RD_ACK samples the master's response.

The transitions are these. START moves any state to ADDR, and STOP moves any state to IDLE. ADDR goes to ADDR_ACK on the SCL fall after 8 bits if the address matches, and to IDLE if it does not. ADDR_ACK goes to RD_BYTE or WR_BYTE on its SCL fall, chosen by R/W. WR_BYTE goes to WR_ACK after 8 bits, and WR_ACK returns to WR_BYTE. RD_BYTE goes to RD_ACK after 8 bits. RD_ACK goes to RD_BYTE if the master acknowledged, and to IDLE if it did not.

Top module: `i2c_regslave`

## Requirements
- R1: After reset `sda_oe` is 0, and register i reads back 0x50 + 0x11·i (0x50, 0x61, 0x72, 0x83, 0x94, 0xA5, 0xB6, 0xC7 for the 8 registers).
- R2: A START is SDA falling while SCL is high. A repeated START, issued with no STOP before it, restarts address reception exactly like a START, including after an address mismatch.
- R3: When the address byte, sent as {address[6:0], R/W} MSB first, matches DEV_ADDR (default 7'h3A), the block holds SDA low through the whole high period of the ninth clock.
- R4: A non-matching address gets no acknowledge, and the block then ignores SCL until a START: a matching address byte clocked without a START is not acknowledged.
- R5: A STOP is SDA rising while SCL is high. After a STOP, SCL is ignored until the next START, and an address byte clocked without a START is not acknowledged.
- R6: In a write, every byte is acknowledged. The first byte after the address loads the pointer. Each later byte is written at the pointer, and the pointer then increments.
- R7: A read sends the register at the pointer MSB first on clocks 1 to 8, releases SDA on clock 9, and increments the pointer after each byte. A master acknowledge (SDA low on clock 9) continues with the next register.
- R8: After a master not-acknowledge (SDA high on clock 9), SDA stays released on all further clocks until a START.
- R9: `sda_oe` changes only while SCL is low.
- R10: While `uvlo` is 1, every register is held at its default value and writes have no effect.
- R11: The pointer uses the low 3 bits of the pointer byte and wraps from register 7 to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Undervoltage flag; holds registers at defaults |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except when it issues a START or a STOP. It never issues a START or a STOP while the slave is pulling SDA low. It holds each SCL level for far more system clocks than the synchronizer depth. The stimulus keeps to these rules by building every bus action from quarter-bit steps of ten system clocks. Before it clocks bytes on an idle bus, it first drops SCL with SDA high, so that a leading zero bit cannot be mistaken for a START.

// File: rtl/i2c_rs_pkg.sv
`timescale 1ns/1ps
package i2c_rs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } i2c_rs_state_e;

endpackage

// File: rtl/i2c_rs_sync.sv
`timescale 1ns/1ps
module i2c_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c_rs_regfile.sv
`timescale 1ns/1ps
module i2c_rs_regfile #(
    parameter int PTR_W    = 3,
    parameter int DEF_BASE = 'h50,
    parameter int DEF_STEP = 'h11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uvlo,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] ptr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data
);

    localparam int NREGS = 1 << PTR_W;

    logic [7:0] regs [NREGS];

    function automatic logic [7:0] def_val(input int idx);
        return 8'((DEF_BASE + DEF_STEP * idx) & 255);
    endfunction

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= def_val(g);
            end else if (uvlo) begin
                regs[g] <= def_val(g);
            end else if (wr_en && ptr == PTR_W'(g)) begin
                regs[g] <= wr_data;
            end
        end
    end

    assign rd_data = regs[ptr];

endmodule

// File: rtl/i2c_rs_fsm.sv
`timescale 1ns/1ps
module i2c_rs_fsm
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3A,
    parameter int         PTR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              sda_oe,
    output i2c_rs_state_e     state
);

    i2c_rs_state_e      nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  rx_sh;
    logic [BYTE_W-1:0]  tx_sh;
    logic               rw_q;
    logic               first_q;
    logic               mack_q;
    logic [PTR_W-1:0]   ptr_q;
    logic               byte_end;
    logic               addr_hit;

    assign byte_end = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit = (rx_sh[7:1] == DEV_ADDR);
    assign wr_en    = (state == ST_WR_BYTE) && byte_end && !first_q
                      && !start_det && !stop_det;
    assign wr_data  = rx_sh;
    assign ptr      = ptr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = mack_q ? ST_RD_BYTE : ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            mack_q  <= 1'b0;
            ptr_q   <= '0;
            sda_oe  <= 1'b0;
        end else if (start_det) begin
            bit_cnt <= '0;
        end else if (stop_det) begin
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                    if (byte_end) begin
                        if (state == ST_ADDR) begin
                            rw_q    <= rx_sh[0];
                            first_q <= 1'b1;
                            sda_oe  <= addr_hit;
                        end else begin
                            sda_oe <= 1'b1;
                            if (first_q) begin
                                ptr_q   <= rx_sh[PTR_W-1:0];
                                first_q <= 1'b0;
                            end else begin
                                ptr_q <= ptr_q + PTR_W'(1);
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR_ACK && rw_q) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) bit_cnt <= bit_cnt + CNT_W'(1);
                    if (byte_end) begin
                        sda_oe <= 1'b0;
                        ptr_q  <= ptr_q + PTR_W'(1);
                    end else if (scl_fall) begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_W-2];
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (mack_q) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_regslave.sv
`timescale 1ns/1ps
module i2c_regslave
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3A,
    parameter int         PTR_W       = 3,
    parameter int         DEF_BASE    = 'h50,
    parameter int         DEF_STEP    = 'h11,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uvlo,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;
    logic [PTR_W-1:0] ptr;
    i2c_rs_state_e    fsm_state;

    i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rs_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .sda_oe    (sda_oe),
        .state     (fsm_state)
    );

    i2c_rs_regfile #(.PTR_W(PTR_W), .DEF_BASE(DEF_BASE), .DEF_STEP(DEF_STEP)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .uvlo    (uvlo),
        .wr_en   (wr_en),
        .ptr     (ptr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/i2c_regslave_chk.sv
`timescale 1ns/1ps
module i2c_regslave_chk
    import i2c_rs_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_s,
    input logic          start_det,
    input logic          stop_det,
    input i2c_rs_state_e state
);

    // R9
    sda_chg_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R2
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    // R5
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R4
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R3
    ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK || state == ST_WR_ACK) |-> sda_oe);

    // R8
    rd_ack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK) |-> !sda_oe);

endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (fsm_state)
);

// File: tb/tb_i2c_regslave.sv
`timescale 1ns/1ps
module tb_i2c_regslave;

    localparam logic [6:0] DEV = 7'h3A;
    localparam int         Q   = 10;

    typedef logic [7:0] bytes8_t [8];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic oe_prev = 1'b0;
    int   checks = 0;
    int   errors = 0;
    int   r9_viol = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_regslave #(.DEV_ADDR(DEV)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .uvlo   (uvlo),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl) r9_viol = r9_viol + 1;
        oe_prev = sda_oe;
    end

    function automatic logic [7:0] dflt(input int i);
        return 8'((8'h50 + 8'h11 * i) & 255);
    endfunction

    task automatic wq(input int n = Q);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic scl_low();
        scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl = 1'b1;
        wq(1); a1 = !sda_bus;
        wq(2 * Q - 2); a2 = !sda_bus;
        wq(1); scl = 1'b0; wq();
        acked = a1 & a2;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            scl = 1'b1; wq(); d = {d[6:0], sda_bus}; wq(); scl = 1'b0; wq();
        end
        sda_m = !master_ack; wq(); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p, input string tag);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); check({tag, " R3 write address ack"}, a, 1);
        send_byte(p, a);           check({tag, " R6 pointer byte ack"}, a, 1);
    endtask

    task automatic wr_regs(input logic [7:0] p, input int n, input bytes8_t dat, input string tag);
        logic a;
        set_ptr(p, tag);
        for (int i = 0; i < n; i++) begin
            send_byte(dat[i], a); check({tag, " R6 data byte ack"}, a, 1);
        end
        bus_stop();
    endtask

    task automatic rd_regs(input logic [7:0] p, input int n, input bytes8_t exp, input string tag);
        logic a;
        logic [7:0] d;
        set_ptr(p, tag);
        bus_rstart();
        send_byte({DEV, 1'b1}, a); check({tag, " R2 read address ack after repeated START"}, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            check($sformatf("%s R7 read byte %0d", tag, i), d, exp[i]);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        bytes8_t e;
        check("R1 sda_oe released after reset", sda_oe, 0);
        for (int i = 0; i < 8; i++) e[i] = dflt(i);
        rd_regs(8'h00, 8, e, "R1 defaults");
    endtask

    task automatic t_write_burst();
        bytes8_t w, e;
        w = '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0};
        wr_regs(8'h02, 3, w, "R6 burst");
        e = '{8'h11, 8'h22, 8'h33, dflt(5), 0, 0, 0, 0};
        rd_regs(8'h02, 4, e, "R6 R7 burst readback");
    endtask

    task automatic t_wrap();
        bytes8_t w, e;
        w = '{8'h99, 8'h98, 0, 0, 0, 0, 0, 0};
        wr_regs(8'h07, 2, w, "R11 write wrap");
        e = '{8'h99, 8'h98, dflt(1), 0, 0, 0, 0, 0};
        rd_regs(8'h07, 3, e, "R11 read wrap");
        e = '{8'h11, 0, 0, 0, 0, 0, 0, 0};
        rd_regs(8'h0A, 1, e, "R11 pointer low bits");
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte({7'h3B, 1'b0}, a); check("R4 wrong address not acked", a, 0);
        send_byte({DEV, 1'b0}, a);   check("R4 address without START ignored", a, 0);
        bus_rstart();
        send_byte({DEV, 1'b0}, a);   check("R2 repeated START after mismatch acks", a, 1);
        bus_stop();
    endtask

    task automatic t_stop_ignore();
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); check("R3 address ack before STOP", a, 1);
        bus_stop();
        scl_low();
        send_byte({DEV, 1'b0}, a); check("R5 address after STOP without START ignored", a, 0);
        bus_stop();
    endtask

    task automatic t_nack_end();
        logic a;
        logic [7:0] d;
        set_ptr(8'h00, "R8 setup");
        bus_rstart();
        send_byte({DEV, 1'b1}, a); check("R8 read address ack", a, 1);
        recv_byte(1'b0, d);        check("R8 last byte before NACK", d, 8'h98);
        recv_byte(1'b0, d);        check("R8 SDA released after NACK", d, 8'hFF);
        check("R8 sda_oe low after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_uvlo();
        bytes8_t w, e;
        w = '{8'h5A, 0, 0, 0, 0, 0, 0, 0};
        wr_regs(8'h03, 1, w, "R10 pre-write");
        e = '{8'h5A, 0, 0, 0, 0, 0, 0, 0};
        rd_regs(8'h03, 1, e, "R10 pre-read");
        uvlo = 1'b1; wq(5); uvlo = 1'b0; wq();
        e = '{dflt(2), dflt(3), 0, 0, 0, 0, 0, 0};
        rd_regs(8'h02, 2, e, "R10 restored after pulse");
        uvlo = 1'b1;
        w = '{8'h77, 0, 0, 0, 0, 0, 0, 0};
        wr_regs(8'h01, 1, w, "R10 write during uvlo");
        uvlo = 1'b0; wq();
        e = '{dflt(1), 0, 0, 0, 0, 0, 0, 0};
        rd_regs(8'h01, 1, e, "R10 write during uvlo had no effect");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_write_burst();
        t_wrap();
        t_mismatch();
        t_stop_ignore();
        t_nack_end();
        t_uvlo();
        check("R9 no sda_oe change while SCL high", r9_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule